// File: doc/BRIEF.md
# Partial Attention Summary Reducer

This block folds a sequence of per-block partial softmax summaries, all belonging to one query, into a single attention result. Upstream engines each scan their own slice of the key/value cache. Each produces three things: the largest score seen in its slice, the sum of the exponentiated scores, and a D-lane vector of value rows weighted by those exponentials. The reducer receives these summaries one per handshake beat and marks the final summary of a query with a last flag. It combines them without ever seeing individual tokens, and then returns the normalised output vector.

Scores are carried in the base-2 exponent domain: the maximum is a signed integer exponent, so bringing a summary to a larger common maximum is an arithmetic right shift by the exponent gap. Internally every denominator and accumulator gains FRAC guard bits below the input's least significant bit. Any summary within FRAC exponent steps of the group maximum is therefore rescaled exactly, and the result does not depend on how the tree paired the summaries. Pending partial results sit in a small per-level register stack, one slot per tree level, and a single merge unit works on them. When the last beat arrives, every occupied level is flushed into the root. A serial divider then divides each accumulator lane by the root denominator.

Top module: `kvr_reduce`

## Requirements
- R1: After reset, in_ready is 1 and out_valid is 0.
- R2: A beat is taken only on a clock edge where in_valid and in_ready are both 1. From the edge that takes a beat with in_last set, in_ready stays 0 until the cycle in which out_valid is 1.
- R3: For a group of one summary (exponent m, denominator l > 0, lanes a[i]), lane i of out_o equals a[i]·2^OFRAC / l, truncated toward zero. in_acc lane i sits at bits [i·AW +: AW] and out_o lane i at bits [i·OW +: OW], both signed two's complement. in_max is a signed two's-complement exponent.
- R4: For a group of 1 to 2^LVLS summaries whose exponents all lie within FRAC of the group maximum M, lane i of out_o equals trunc(2^OFRAC·Σ a_b[i]·2^(m_b−M) / Σ l_b·2^(m_b−M)). This holds for odd counts and whatever the arrival order.
- R5: A summary whose exponent is more than FRAC below the exponent of every other non-empty summary of its group adds nothing to the numerator or the denominator.
- R6: An empty summary (l = 0, all lanes 0, exponent −2^(MW−1)) has no effect on the result, wherever it appears in the group.
- R7: out_valid is high for exactly one cycle per group. out_o holds its value in every cycle where out_valid is 0.
- R8: If every summary of a group has l = 0, all lanes of out_o are 0.
- R9: Each group's result depends only on that group's summaries. Groups may follow one another back to back.
- R10: At the default parameters, out_valid rises at most 200 clock cycles after the edge that takes the last beat of a group.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A summary is offered |
| in_ready | output | 1 | Reducer can take a summary this cycle |
| in_last | input | 1 | Offered summary closes the current group |
| in_max | input | MW | Signed base-2 exponent of the block maximum |
| in_den | input | LW | Unsigned block denominator |
| in_acc | input | D*AW | Signed weighted-value lanes |
| out_valid | output | 1 | One-cycle strobe: out_o carries a new result |
| out_o | output | D*OW | Signed normalised output lanes, OFRAC fraction bits |

## Verification
A slot left valid after a flush, or a lost carry, damages the next group rather than the current one. The bench therefore runs many groups back to back and compares every result, so such a fault shows up at the very next out_valid. A wrong rescale shift or a wrong exponent choice shows in out_o of the same group. The bench makes such a fault visible by mixing exponents up to FRAC apart, and by placing empty and far-below summaries at different positions in the group. A stalled flush or divider shows as a missing out_valid within the latency bound, or as in_ready never returning.

// File: rtl/kvr_pkg.sv
package kvr_pkg;
  typedef enum logic [0:0] {
    PH_COLLECT = 1'b0,
    PH_DIVIDE  = 1'b1
  } phase_t;
endpackage

// File: rtl/kvr_merge.sv
module kvr_merge #(
  parameter int MW   = 8,
  parameter int LIW  = 35,
  parameter int AIW  = 35,
  parameter int D    = 4,
  parameter int FRAC = 16
) (
  input  logic signed [MW-1:0] ma,
  input  logic [LIW-1:0]       la,
  input  logic [D*AIW-1:0]     aa,
  input  logic signed [MW-1:0] mb,
  input  logic [LIW-1:0]       lb,
  input  logic [D*AIW-1:0]     ab,
  output logic signed [MW-1:0] mo,
  output logic [LIW-1:0]       lo,
  output logic [D*AIW-1:0]     ao
);
  localparam int DW = MW + 1;

  function automatic logic [DW-1:0] exp_gap(input logic signed [MW-1:0] hi,
                                            input logic signed [MW-1:0] lw);
    logic signed [DW-1:0] hx;
    logic signed [DW-1:0] lx;
    hx = {hi[MW-1], hi};
    lx = {lw[MW-1], lw};
    return DW'(hx - lx);
  endfunction

  function automatic logic [LIW-1:0] shift_den(input logic [LIW-1:0] x,
                                               input logic [DW-1:0] d);
    if (int'(d) > FRAC) return '0;
    return x >> d;
  endfunction

  function automatic logic signed [AIW-1:0] shift_acc(input logic signed [AIW-1:0] x,
                                                      input logic [DW-1:0] d);
    if (int'(d) > FRAC) return '0;
    return x >>> d;
  endfunction

  logic [DW-1:0] gap_a;
  logic [DW-1:0] gap_b;

  always_comb begin
    mo    = (ma > mb) ? ma : mb;
    gap_a = exp_gap(mo, ma);
    gap_b = exp_gap(mo, mb);
    lo    = shift_den(la, gap_a) + shift_den(lb, gap_b);
  end

  for (genvar g = 0; g < D; g++) begin : g_lane
    logic signed [AIW-1:0] lane_a;
    logic signed [AIW-1:0] lane_b;
    assign lane_a = aa[g*AIW +: AIW];
    assign lane_b = ab[g*AIW +: AIW];
    assign ao[g*AIW +: AIW] = shift_acc(lane_a, gap_a) + shift_acc(lane_b, gap_b);
  end
endmodule

// File: rtl/kvr_stack.sv
module kvr_stack #(
  parameter int MW   = 8,
  parameter int LW   = 16,
  parameter int AW   = 16,
  parameter int D    = 4,
  parameter int FRAC = 16,
  parameter int LVLS = 3,
  parameter int LIW  = LW + FRAC + LVLS,
  parameter int AIW  = AW + FRAC + LVLS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 take,
  input  logic                 take_last,
  input  logic signed [MW-1:0] take_m,
  input  logic [LW-1:0]        take_l,
  input  logic [D*AW-1:0]      take_a,
  output logic                 busy,
  output logic                 root_v,
  output logic [LIW-1:0]       root_l,
  output logic [D*AIW-1:0]     root_a
);
  localparam int LB = $clog2(LVLS + 1);

  logic [LVLS-1:0]       slot_v;
  logic signed [MW-1:0]  slot_m [LVLS];
  logic [LIW-1:0]        slot_l [LVLS];
  logic [D*AIW-1:0]      slot_a [LVLS];

  logic                  carry_v;
  logic                  carry_last;
  logic [LB-1:0]         carry_lvl;
  logic signed [MW-1:0]  carry_m;
  logic [LIW-1:0]        carry_l;
  logic [D*AIW-1:0]      carry_a;

  logic [LIW-1:0]        wide_l;
  logic [D*AIW-1:0]      wide_a;

  logic [LB-1:0]         sel;
  logic                  lvl_ok;
  logic                  hit;
  logic                  upper_any;
  logic                  ev_merge;
  logic                  ev_store;
  logic                  ev_pass;
  logic                  ev_root;

  logic signed [MW-1:0]  mrg_m;
  logic [LIW-1:0]        mrg_l;
  logic [D*AIW-1:0]      mrg_a;

  function automatic logic [LIW-1:0] widen_den(input logic [LW-1:0] x);
    return LIW'(x) << FRAC;
  endfunction

  function automatic logic [AIW-1:0] widen_acc(input logic [AW-1:0] x);
    logic [AIW-1:0] sx;
    sx = {{(AIW-AW){x[AW-1]}}, x};
    return sx << FRAC;
  endfunction

  assign wide_l = widen_den(take_l);
  for (genvar g = 0; g < D; g++) begin : g_wide
    assign wide_a[g*AIW +: AIW] = widen_acc(take_a[g*AW +: AW]);
  end

  always_comb begin
    lvl_ok    = (int'(carry_lvl) < LVLS);
    sel       = lvl_ok ? carry_lvl : '0;
    hit       = lvl_ok && slot_v[sel];
    upper_any = 1'b0;
    for (int j = 0; j < LVLS; j++) begin
      if (slot_v[j] && (j >= int'(carry_lvl))) upper_any = 1'b1;
    end
    ev_merge = carry_v && hit;
    ev_store = carry_v && !hit && !carry_last;
    ev_pass  = carry_v && !hit && carry_last && upper_any;
    ev_root  = carry_v && !hit && carry_last && !upper_any;
  end

  kvr_merge #(
    .MW(MW), .LIW(LIW), .AIW(AIW), .D(D), .FRAC(FRAC)
  ) u_merge (
    .ma(slot_m[sel]), .la(slot_l[sel]), .aa(slot_a[sel]),
    .mb(carry_m),     .lb(carry_l),     .ab(carry_a),
    .mo(mrg_m),       .lo(mrg_l),       .ao(mrg_a)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_v     <= '0;
      carry_v    <= 1'b0;
      carry_last <= 1'b0;
      carry_lvl  <= '0;
      carry_m    <= '0;
      carry_l    <= '0;
      carry_a    <= '0;
      for (int j = 0; j < LVLS; j++) begin
        slot_m[j] <= '0;
        slot_l[j] <= '0;
        slot_a[j] <= '0;
      end
    end else if (take) begin
      carry_v    <= 1'b1;
      carry_last <= take_last;
      carry_lvl  <= '0;
      carry_m    <= take_m;
      carry_l    <= wide_l;
      carry_a    <= wide_a;
    end else if (ev_merge) begin
      carry_m     <= mrg_m;
      carry_l     <= mrg_l;
      carry_a     <= mrg_a;
      carry_lvl   <= carry_lvl + 1'b1;
      slot_v[sel] <= 1'b0;
    end else if (ev_store) begin
      slot_v[sel] <= 1'b1;
      slot_m[sel] <= carry_m;
      slot_l[sel] <= carry_l;
      slot_a[sel] <= carry_a;
      carry_v     <= 1'b0;
    end else if (ev_pass) begin
      carry_lvl <= carry_lvl + 1'b1;
    end else if (ev_root) begin
      carry_v <= 1'b0;
    end
  end

  assign busy   = carry_v;
  assign root_v = ev_root;
  assign root_l = carry_l;
  assign root_a = carry_a;

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (carry_v && !carry_last) |-> (int'(carry_lvl) < LVLS));

  // R4
  merge_max_grows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_merge |=> (carry_m >= $past(carry_m)) && (carry_m >= $past(slot_m[sel])));

  // R2
  take_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> !carry_v);

  // R9
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_root |-> (slot_v == '0));
endmodule

// File: rtl/kvr_div.sv
module kvr_div #(
  parameter int LIW   = 35,
  parameter int AIW   = 35,
  parameter int D     = 4,
  parameter int OFRAC = 8,
  parameter int OW    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LIW-1:0]   den,
  input  logic [D*AIW-1:0] num,
  output logic             busy,
  output logic             done,
  output logic [D*OW-1:0]  quo_flat
);
  localparam int NW = AIW + OFRAC;
  localparam int KB = (D > 1) ? $clog2(D) : 1;
  localparam int CB = $clog2(NW + 1);

  logic [LIW-1:0]   den_r;
  logic [D*AIW-1:0] num_r;
  logic [KB-1:0]    k;
  logic [CB-1:0]    cnt;
  logic [LIW-1:0]   rem;
  logic [NW-1:0]    shr;
  logic [NW-1:0]    quo;
  logic             neg;

  logic [LIW:0]     rem_sh;
  logic             ge;
  logic [LIW:0]     rem_nx;
  logic [NW-1:0]    q_nx;
  logic             last_bit;
  logic [OW-1:0]    lane_res;

  function automatic logic [AIW-1:0] magnitude(input logic [AIW-1:0] v);
    return v[AIW-1] ? (~v + 1'b1) : v;
  endfunction

  function automatic logic [OW-1:0] signed_result(input logic [NW-1:0] q,
                                                  input logic n,
                                                  input logic zero_den);
    logic signed [NW:0] sv;
    sv = $signed({1'b0, q});
    if (n) sv = -sv;
    if (zero_den) return '0;
    return OW'(sv);
  endfunction

  always_comb begin
    rem_sh   = {rem, shr[NW-1]};
    ge       = (rem_sh >= {1'b0, den_r});
    rem_nx   = ge ? (rem_sh - {1'b0, den_r}) : rem_sh;
    q_nx     = {quo[NW-2:0], ge};
    last_bit = (int'(cnt) == NW - 1);
    lane_res = signed_result(q_nx, neg, den_r == '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      quo_flat <= '0;
      den_r    <= '0;
      num_r    <= '0;
      k        <= '0;
      cnt      <= '0;
      rem      <= '0;
      shr      <= '0;
      quo      <= '0;
      neg      <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        busy  <= 1'b1;
        den_r <= den;
        num_r <= num;
        k     <= '0;
        cnt   <= '0;
        rem   <= '0;
        quo   <= '0;
        neg   <= num[AIW-1];
        shr   <= {magnitude(num[AIW-1:0]), {OFRAC{1'b0}}};
      end else if (busy) begin
        if (!last_bit) begin
          rem <= rem_nx[LIW-1:0];
          shr <= shr << 1;
          quo <= q_nx;
          cnt <= cnt + 1'b1;
        end else begin
          quo_flat[int'(k)*OW +: OW] <= lane_res;
          if (int'(k) == D - 1) begin
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            k   <= k + 1'b1;
            cnt <= '0;
            rem <= '0;
            quo <= '0;
            neg <= num_r[(int'(k)+1)*AIW + AIW - 1];
            shr <= {magnitude(num_r[(int'(k)+1)*AIW +: AIW]), {OFRAC{1'b0}}};
          end
        end
      end
    end
  end

  // R2
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);

  // R3
  lane_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (int'(k) < D));

  // R10
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy) && !busy);
endmodule

// File: rtl/kvr_reduce.sv
module kvr_reduce #(
  parameter int MW    = 8,
  parameter int LW    = 16,
  parameter int AW    = 16,
  parameter int D     = 4,
  parameter int FRAC  = 16,
  parameter int LVLS  = 3,
  parameter int OFRAC = 8,
  parameter int OW    = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic                 in_last,
  input  logic signed [MW-1:0] in_max,
  input  logic [LW-1:0]        in_den,
  input  logic [D*AW-1:0]      in_acc,
  output logic                 out_valid,
  output logic [D*OW-1:0]      out_o
);
  import kvr_pkg::*;

  localparam int LIW = LW + FRAC + LVLS;
  localparam int AIW = AW + FRAC + LVLS;

  phase_t            ph_q;
  logic              take;
  logic              stack_busy;
  logic              root_v;
  logic [LIW-1:0]    root_l;
  logic [D*AIW-1:0]  root_a;
  logic              div_busy;
  logic              div_done;
  logic [D*OW-1:0]   div_q;

  assign in_ready = (ph_q == PH_COLLECT) && !stack_busy;
  assign take     = in_valid && in_ready;

  kvr_stack #(
    .MW(MW), .LW(LW), .AW(AW), .D(D), .FRAC(FRAC), .LVLS(LVLS),
    .LIW(LIW), .AIW(AIW)
  ) u_stack (
    .clk(clk), .rst_n(rst_n),
    .take(take), .take_last(in_last), .take_m(in_max),
    .take_l(in_den), .take_a(in_acc),
    .busy(stack_busy), .root_v(root_v), .root_l(root_l), .root_a(root_a)
  );

  kvr_div #(
    .LIW(LIW), .AIW(AIW), .D(D), .OFRAC(OFRAC), .OW(OW)
  ) u_div (
    .clk(clk), .rst_n(rst_n),
    .start(root_v), .den(root_l), .num(root_a),
    .busy(div_busy), .done(div_done), .quo_flat(div_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q      <= PH_COLLECT;
      out_valid <= 1'b0;
      out_o     <= '0;
    end else begin
      out_valid <= div_done;
      if (div_done) out_o <= div_q;
      if (root_v) ph_q <= PH_DIVIDE;
      else if (div_done) ph_q <= PH_COLLECT;
    end
  end

  // R2
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_last) |=> !in_ready);

  // R2
  divide_blocks_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_busy |-> !in_ready);

  // R7
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  // R7
  hold_output_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_o));
endmodule

// File: tb/sim_kvr_reduce.sv
module sim_kvr_reduce;
  localparam int MW = 8, LW = 16, AW = 16, D = 4, FRAC = 16, LVLS = 3, OFRAC = 8, OW = 32;
  localparam int MAXB = 1 << LVLS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic in_last = 1'b0;
  logic signed [MW-1:0] in_max = '0;
  logic [LW-1:0] in_den = '0;
  logic [D*AW-1:0] in_acc = '0;
  logic out_valid;
  logic [D*OW-1:0] out_o;

  int checks = 0;
  int fails = 0;
  int nb;
  int bm [MAXB];
  int bl [MAXB];
  int ba [MAXB][D];
  longint exp_o [D];

  always #5 clk = ~clk;

  kvr_reduce u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_last(in_last), .in_max(in_max), .in_den(in_den), .in_acc(in_acc),
    .out_valid(out_valid), .out_o(out_o)
  );

  task automatic check(input bit ok, input string rq, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, expv);
    end
  endtask

  task automatic compute_expected();
    int mx = -100000;
    longint ls = 0;
    longint as_ [D];
    for (int i = 0; i < D; i++) as_[i] = 0;
    for (int b = 0; b < nb; b++) if (bl[b] > 0 && bm[b] > mx) mx = bm[b];
    for (int b = 0; b < nb; b++) begin
      if (bl[b] > 0 && (mx - bm[b]) <= FRAC) begin
        ls += longint'(bl[b]) <<< (FRAC - (mx - bm[b]));
        for (int i = 0; i < D; i++) as_[i] += longint'(ba[b][i]) <<< (FRAC - (mx - bm[b]));
      end
    end
    for (int i = 0; i < D; i++) exp_o[i] = (ls == 0) ? 0 : (as_[i] <<< OFRAC) / ls;
  endtask

  task automatic fill_random(input int b, input int base, input int spread);
    bm[b] = base - int'($urandom_range(0, spread));
    bl[b] = int'($urandom_range(1, 65535));
    for (int i = 0; i < D; i++) ba[b][i] = int'($urandom_range(0, 65535)) - 32768;
  endtask

  task automatic fill_empty(input int b);
    bm[b] = -128;
    bl[b] = 0;
    for (int i = 0; i < D; i++) ba[b][i] = 0;
  endtask

  task automatic run_group(input string rq);
    int lat;
    logic [D*OW-1:0] held;
    compute_expected();
    for (int b = 0; b < nb; b++) begin
      @(negedge clk);
      in_valid = 1'b0;
      repeat ($urandom_range(0, 2)) begin
        in_max = MW'($urandom);
        in_den = LW'($urandom);
        @(negedge clk);
      end
      in_valid = 1'b1;
      in_last  = (b == nb - 1);
      in_max   = MW'(bm[b]);
      in_den   = LW'(bl[b]);
      for (int i = 0; i < D; i++) in_acc[i*AW +: AW] = AW'(ba[b][i]);
      while (!in_ready) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_last  = 1'b0;
    // R2: no new beat is taken while the group is being finished
    check(in_ready == 1'b0, "R2 ready low after last", longint'(in_ready), 0);
    lat = 1;
    while (!out_valid && lat < 400) begin
      in_valid = (lat % 3 == 0);
      @(negedge clk);
      lat++;
    end
    in_valid = 1'b0;
    // R10 latency bound
    check(out_valid && lat <= 200, "R10 latency", longint'(lat), 200);
    for (int i = 0; i < D; i++) begin
      logic signed [OW-1:0] got;
      got = out_o[i*OW +: OW];
      check(longint'(got) == longint'(OW'(exp_o[i])), rq, longint'(got), exp_o[i]);
    end
    held = out_o;
    @(negedge clk);
    // R7 single-cycle strobe
    check(out_valid == 1'b0, "R7 pulse one cycle", longint'(out_valid), 0);
    repeat (2) @(negedge clk);
    // R7 output held between results
    check(out_o == held, "R7 output held", longint'(out_o[OW-1:0]), longint'(held[OW-1:0]));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R10 actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(in_ready == 1'b1, "R1 ready after reset", longint'(in_ready), 1);
    check(out_valid == 1'b0, "R1 no output after reset", longint'(out_valid), 0);

    // R3 single summary
    nb = 1; fill_random(0, 10, 0);
    run_group("R3 single block");
    nb = 1; fill_random(0, -90, 0);
    run_group("R3 single block negative exponent");

    // R4 two, three and full groups
    nb = 2; for (int b = 0; b < nb; b++) fill_random(b, 40, 16);
    run_group("R4 two blocks");
    nb = 3; for (int b = 0; b < nb; b++) fill_random(b, -20, 16);
    run_group("R4 three blocks");
    nb = MAXB; for (int b = 0; b < nb; b++) fill_random(b, 100, 16);
    run_group("R4 eight blocks");

    // R5 far-below summary dropped, at several positions
    for (int pos = 0; pos < 3; pos++) begin
      nb = 5;
      for (int b = 0; b < nb; b++) fill_random(b, 60, 8);
      bm[pos * 2] = 20;
      run_group("R5 far block ignored");
    end

    // R6 empty summaries in the middle, first and last
    nb = 4; for (int b = 0; b < nb; b++) fill_random(b, 5, 16);
    fill_empty(1);
    run_group("R6 empty in middle");
    nb = 3; for (int b = 0; b < nb; b++) fill_random(b, -50, 16);
    fill_empty(0); fill_empty(2);
    run_group("R6 empty at ends");

    // R8 all empty
    nb = 3; for (int b = 0; b < nb; b++) fill_empty(b);
    run_group("R8 zero denominator");

    // R9 back-to-back random groups, varied sizes and exponents
    for (int t = 0; t < 30; t++) begin
      int base;
      nb = int'($urandom_range(1, MAXB));
      base = int'($urandom_range(0, 200)) - 100;
      for (int b = 0; b < nb; b++) fill_random(b, base, 16);
      if (nb > 2 && ($urandom_range(0, 3) == 0)) fill_empty(int'($urandom_range(0, nb - 1)));
      run_group("R9 R4 random group");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule